// File: doc/BRIEF.md
# Base Address Window Decoder

This block holds the base registers of up to six ordinary address windows and one expansion-ROM window. It holds the two enable bits of a command register. From these it works out, at every moment, which windows are live. Each window has a power-of-two size and a kind, either I/O or memory. Both are fixed by parameters when the block is built. A write port programs the registers. The base value written is aligned down to the window size, so the low bits that a size covers are dropped.

A transaction address and its kind enter on the lookup inputs. The block answers in the same cycle with a hit flag and the index of the claiming window. When two live windows overlap, the lower index claims the address. A window that is not live claims nothing. A one-cycle pulse reports each change in the set of live windows or in the base of a live window, so that a neighbouring fabric can refresh any copy of the map it holds.

Top module: `baseWindowDecoder`

## Requirements
- R1: After reset the command enables, all bases and the ROM enable are zero, so every bit of `mapValid` is 0, `hit` is 0 and `mapChanged` is 0.
- R2: A base write keeps the written value with its low log2(size) bits cleared. The window then covers every address from that base through base + size − 1, and nothing outside that range.
- R3: An I/O window can be live only while command bit 0 is 1. A memory window, the ROM window included, can be live only while command bit 1 is 1.
- R4: An I/O window is never live when its base is zero, when its last address is not above its base, or when its last address is 0x10000 or higher.
- R5: A memory window is never live when its base is zero, when its last address is not above its base, or when its last address is all ones.
- R6: The ROM window (index NUM_BAR) is live only while bit 0 of the last value written to its base register is 1.
- R7: A live window claims an address only when `lookupIsIo` is 1 for an I/O window, or 0 for a memory window.
- R8: When several live windows claim one address, `hit` is 1 and `hitIdx` gives the lowest such index. When none claims it, `hit` and `hitIdx` are 0.
- R9: `mapChanged` is 1 for exactly the one cycle that follows a clock edge at which the live set, or the base of any live window, changed. A write that changes neither does not raise it.
- R10: The write map uses byte offsets on `wrAddr`. Offset 0x04 is the command register: bit 0 enables I/O and bit 1 enables memory. Offsets 0x10 + 4·i are the bases of windows i = 0..5, and offset 0x30 is the ROM base. A write to any other offset changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 8 | Byte offset of the register written |
| wrData | input | 32 | Write value |
| lookupAddr | input | 32 | Transaction address to decode |
| lookupIsIo | input | 1 | 1 for an I/O transaction, 0 for memory |
| hit | output | 1 | Some live window claims the address |
| hitIdx | output | 3 | Index of the claiming window |
| mapValid | output | 7 | One bit per window, 1 while the window is live |
| mapChanged | output | 1 | One-cycle pulse after any map change |

## Verification
The bench probes each window at five points: one below the base, the base, the middle, the last address and one past it. It sends each probe under both transaction kinds, so that off-by-one range edges and kind mismatches show up as separate errors. Two windows share a base, which exercises the priority between overlapping windows. The command enables step through off, I/O only, both and memory only, which tells the I/O gate apart from the memory gate. Bases are then moved onto each rule that makes a window dead: zero, past the 64K I/O limit, an end of all ones, and the ROM enable cleared. The change pulse is compared after every write against the bench's own before and after copies of the map.

// File: rtl/bwdPkg.sv
package bwdPkg;
  localparam int SEL_W = 4;

  typedef struct packed {
    logic             cmdWe;
    logic             winWe;
    logic [SEL_W-1:0] winSel;
  } bwdStrobe_t;
endpackage

// File: rtl/bwdWriteCtrl.sv
module bwdWriteCtrl
  import bwdPkg::*;
#(
  parameter int REG_AW   = 8,
  parameter int NUM_BAR  = 6,
  parameter int CMD_OFS  = 'h04,
  parameter int BASE_OFS = 'h10,
  parameter int ROM_OFS  = 'h30
) (
  input  logic              wrEn,
  input  logic [REG_AW-1:0] wrAddr,
  output bwdStrobe_t        strobe
);
  logic [NUM_BAR:0] selHot;

  for (genvar i = 0; i <= NUM_BAR; i++) begin : gSel
    localparam int OFS = (i == NUM_BAR) ? ROM_OFS : BASE_OFS + 4 * i;
    assign selHot[i] = (wrAddr == REG_AW'(OFS));
  end

  always_comb begin
    strobe.cmdWe  = wrEn && (wrAddr == REG_AW'(CMD_OFS));
    strobe.winWe  = wrEn && (selHot != '0);
    strobe.winSel = '0;
    for (int i = 0; i <= NUM_BAR; i++) begin
      if (selHot[i]) strobe.winSel = SEL_W'(i);
    end
  end
endmodule

// File: rtl/bwdWindowPath.sv
module bwdWindowPath
  import bwdPkg::*;
#(
  parameter int NUM_BAR       = 6,
  parameter int ADDR_W        = 32,
  parameter int IO_LIMIT_LOG2 = 16,
  parameter int unsigned WIN_LOG2 [NUM_BAR+1] = '{4, 12, 8, 20, 4, 2, 16},
  parameter logic [NUM_BAR:0] WIN_IS_IO = 7'b0100101,
  localparam int NUM_WIN = NUM_BAR + 1,
  localparam int IDX_W   = $clog2(NUM_WIN)
) (
  input  logic               clk,
  input  logic               rstN,
  input  bwdStrobe_t         strobe,
  input  logic [ADDR_W-1:0]  wrData,
  input  logic [ADDR_W-1:0]  lookupAddr,
  input  logic               lookupIsIo,
  output logic [NUM_WIN-1:0] mapValid,
  output logic               hit,
  output logic [IDX_W-1:0]   hitIdx,
  output logic               mapChanged,
  output logic               ioEn,
  output logic               memEn,
  output logic               romEn
);
  localparam logic [ADDR_W:0] IO_LIMIT = (ADDR_W+1)'(64'd1 << IO_LIMIT_LOG2);

  logic [NUM_WIN-1:0]             match;
  logic [NUM_WIN-1:0][ADDR_W-1:0] liveBase, liveBaseQ;
  logic [NUM_WIN-1:0]             mapValidQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ioEn  <= 1'b0;
      memEn <= 1'b0;
      romEn <= 1'b0;
    end else begin
      if (strobe.cmdWe) begin
        ioEn  <= wrData[0];
        memEn <= wrData[1];
      end
      if (strobe.winWe && strobe.winSel == SEL_W'(NUM_BAR)) romEn <= wrData[0];
    end
  end

  for (genvar i = 0; i < NUM_WIN; i++) begin : gWin
    localparam logic [ADDR_W-1:0] LOW = ADDR_W'((64'd1 << WIN_LOG2[i]) - 64'd1);
    logic [ADDR_W-1:0] baseQ;
    logic [ADDR_W:0]   endAddr;
    logic              shapeOk, gateOk;

    always_ff @(posedge clk) begin
      if (!rstN) baseQ <= '0;
      else if (strobe.winWe && strobe.winSel == SEL_W'(i)) baseQ <= wrData & ~LOW;
    end

    assign endAddr = {1'b0, baseQ} + {1'b0, LOW};

    if (WIN_IS_IO[i]) begin : gIo
      assign shapeOk = (baseQ != '0) && (endAddr > {1'b0, baseQ}) && (endAddr < IO_LIMIT);
      assign gateOk  = ioEn;
    end else begin : gMem
      assign shapeOk = (baseQ != '0) && (endAddr > {1'b0, baseQ}) &&
                       (endAddr[ADDR_W-1:0] != '1) && !endAddr[ADDR_W];
      if (i == NUM_BAR) begin : gRom
        assign gateOk = memEn && romEn;
      end else begin : gBar
        assign gateOk = memEn;
      end
    end

    assign mapValid[i] = shapeOk && gateOk;
    assign liveBase[i] = mapValid[i] ? baseQ : '0;
    assign match[i]    = mapValid[i] && (lookupIsIo == WIN_IS_IO[i]) &&
                         ({1'b0, lookupAddr} >= {1'b0, baseQ}) &&
                         ({1'b0, lookupAddr} <= endAddr);
  end

  always_comb begin
    hit    = |match;
    hitIdx = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (match[i]) hitIdx = IDX_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mapValidQ <= '0;
      liveBaseQ <= '0;
    end else begin
      mapValidQ <= mapValid;
      liveBaseQ <= liveBase;
    end
  end

  assign mapChanged = (mapValidQ != mapValid) || (liveBaseQ != liveBase);
endmodule

// File: rtl/baseWindowDecoder.sv
module baseWindowDecoder
  import bwdPkg::*;
#(
  parameter int REG_AW        = 8,
  parameter int NUM_BAR       = 6,
  parameter int ADDR_W        = 32,
  parameter int IO_LIMIT_LOG2 = 16,
  parameter int unsigned WIN_LOG2 [NUM_BAR+1] = '{4, 12, 8, 20, 4, 2, 16},
  parameter logic [NUM_BAR:0] WIN_IS_IO = 7'b0100101,
  localparam int NUM_WIN = NUM_BAR + 1,
  localparam int IDX_W   = $clog2(NUM_WIN)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [REG_AW-1:0]  wrAddr,
  input  logic [ADDR_W-1:0]  wrData,
  input  logic [ADDR_W-1:0]  lookupAddr,
  input  logic               lookupIsIo,
  output logic               hit,
  output logic [IDX_W-1:0]   hitIdx,
  output logic [NUM_WIN-1:0] mapValid,
  output logic               mapChanged
);
  bwdStrobe_t strobe;
  logic       ioEn, memEn, romEn;

  bwdWriteCtrl #(.REG_AW(REG_AW), .NUM_BAR(NUM_BAR)) uCtrl (
    .wrEn  (wrEn),
    .wrAddr(wrAddr),
    .strobe(strobe)
  );

  bwdWindowPath #(
    .NUM_BAR(NUM_BAR), .ADDR_W(ADDR_W), .IO_LIMIT_LOG2(IO_LIMIT_LOG2),
    .WIN_LOG2(WIN_LOG2), .WIN_IS_IO(WIN_IS_IO)
  ) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrData    (wrData),
    .lookupAddr(lookupAddr),
    .lookupIsIo(lookupIsIo),
    .mapValid  (mapValid),
    .hit       (hit),
    .hitIdx    (hitIdx),
    .mapChanged(mapChanged),
    .ioEn      (ioEn),
    .memEn     (memEn),
    .romEn     (romEn)
  );
endmodule

// File: rtl/bwdChecker.sv
module bwdChecker #(
  parameter int NUM_BAR = 6,
  parameter logic [NUM_BAR:0] WIN_IS_IO = 7'b0100101,
  localparam int NUM_WIN = NUM_BAR + 1,
  localparam int IDX_W   = $clog2(NUM_WIN)
) (
  input logic               clk,
  input logic               rstN,
  input logic               wrEn,
  input logic               lookupIsIo,
  input logic               hit,
  input logic [IDX_W-1:0]   hitIdx,
  input logic [NUM_WIN-1:0] mapValid,
  input logic               mapChanged,
  input logic               ioEn,
  input logic               memEn,
  input logic               romEn
);
  AST_IO_GATED: assert property (@(posedge clk) disable iff (!rstN)
    !ioEn |-> ((mapValid & WIN_IS_IO) == '0));  // R3
  AST_MEM_GATED: assert property (@(posedge clk) disable iff (!rstN)
    !memEn |-> ((mapValid & ~WIN_IS_IO) == '0));  // R3
  AST_ROM_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    mapValid[NUM_BAR] |-> romEn);  // R6
  AST_KIND_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> (lookupIsIo == WIN_IS_IO[hitIdx]));  // R7
  AST_HIT_LIVE: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> mapValid[hitIdx]);  // R8
  AST_CHANGE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    mapChanged |-> $past(wrEn));  // R9
  AST_MAP_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !$past(wrEn) |-> $stable(mapValid));  // R9
endmodule

bind baseWindowDecoder bwdChecker #(.NUM_BAR(NUM_BAR), .WIN_IS_IO(WIN_IS_IO)) uChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .lookupIsIo(lookupIsIo), .hit(hit),
  .hitIdx(hitIdx), .mapValid(mapValid), .mapChanged(mapChanged),
  .ioEn(ioEn), .memEn(memEn), .romEn(romEn)
);

// File: tb/sim_baseWindowDecoder.sv
`timescale 1ns/1ps
module sim_baseWindowDecoder;
  localparam int NW = 7;
  localparam int unsigned LOG2 [NW] = '{4, 12, 8, 20, 4, 2, 16};
  localparam logic [NW-1:0] ISIO = 7'b0100101;

  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0, lookupIsIo = 1'b0;
  logic [7:0] wrAddr = '0;
  logic [31:0] wrData = '0, lookupAddr = '0;
  logic hit, mapChanged;
  logic [2:0] hitIdx;
  logic [NW-1:0] mapValid;

  int total = 0, bad = 0;
  bit finished = 0;
  longint unsigned bBase [NW];
  bit bIo = 0, bMem = 0, bRom = 0;

  always #2 clk = ~clk;

  baseWindowDecoder #(.WIN_LOG2(LOG2), .WIN_IS_IO(ISIO)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .lookupAddr(lookupAddr), .lookupIsIo(lookupIsIo), .hit(hit), .hitIdx(hitIdx),
    .mapValid(mapValid), .mapChanged(mapChanged)
  );

  task automatic check(string tag, longint unsigned act, longint unsigned exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit live(int i);
    longint unsigned sz = 64'd1 << LOG2[i];
    longint unsigned e = bBase[i] + sz - 1;
    if (bBase[i] == 0 || e <= bBase[i]) return 0;
    if (ISIO[i]) return bIo && e < 64'h10000;
    if (e >= 64'hFFFF_FFFF) return 0;
    if (i == NW - 1) return bMem && bRom;
    return bMem;
  endfunction

  function automatic logic [NW-1:0] liveMask();
    logic [NW-1:0] m;
    for (int i = 0; i < NW; i++) m[i] = live(i);
    return m;
  endfunction

  function automatic int claimer(longint unsigned a, bit io);
    for (int i = 0; i < NW; i++) begin
      longint unsigned sz = 64'd1 << LOG2[i];
      if (live(i) && ISIO[i] == io && a >= bBase[i] && a <= bBase[i] + sz - 1) return i;
    end
    return -1;
  endfunction

  // R9 / R10: write, then compare the pulse against before/after model maps
  task automatic writeReg(byte unsigned ofs, int unsigned val, string tag);
    logic [NW-1:0] m0 = liveMask();
    longint unsigned b0 [NW];
    bit chg;
    for (int i = 0; i < NW; i++) b0[i] = live(i) ? bBase[i] : 0;
    @(negedge clk);
    wrEn = 1'b1; wrAddr = ofs; wrData = val;
    if (ofs == 8'h04) begin bIo = val[0]; bMem = val[1]; end
    else if (ofs == 8'h30) begin bBase[NW-1] = val & ~((1 << LOG2[NW-1]) - 1); bRom = val[0]; end
    else if (ofs >= 8'h10 && ofs <= 8'h24 && ofs[1:0] == 2'b00)
      bBase[(ofs - 8'h10) / 4] = val & ~((1 << LOG2[(ofs - 8'h10) / 4]) - 1);
    @(negedge clk);
    wrEn = 1'b0;
    chg = (liveMask() != m0);
    for (int i = 0; i < NW; i++) if ((live(i) ? bBase[i] : 0) != b0[i]) chg = 1;
    check({"R9 pulse ", tag}, mapChanged, chg);
    check({"R10 map ", tag}, mapValid, liveMask());
    @(negedge clk);
    check({"R9 drop ", tag}, mapChanged, 0);
  endtask

  task automatic probe(longint unsigned a, bit io);
    int c;
    lookupAddr = a[31:0]; lookupIsIo = io;
    #0.5;
    c = claimer(a, io);
    check("R8 R7 R2 hit", hit, c >= 0);
    check("R8 R2 idx", hitIdx, c >= 0 ? c : 0);
  endtask

  task automatic sweep();
    for (int i = 0; i < NW; i++) begin
      longint unsigned sz = 64'd1 << LOG2[i];
      longint unsigned pts [5];
      pts = '{bBase[i] - 1, bBase[i], bBase[i] + sz / 2, bBase[i] + sz - 1, bBase[i] + sz};
      for (int p = 0; p < 5; p++) begin
        if (pts[p] <= 64'hFFFF_FFFF) begin
          probe(pts[p], 1'b0);
          probe(pts[p], 1'b1);
        end
      end
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NW; i++) bBase[i] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 mapValid", mapValid, 0);
    check("R1 hit", hit, 0);
    check("R1 mapChanged", mapChanged, 0);

    // R2 unaligned writes while disabled: nothing live (R3), no pulse (R9)
    writeReg(8'h10, 32'h0000_100F, "w0");
    writeReg(8'h14, 32'h1000_0FFF, "w1");
    writeReg(8'h18, 32'h0000_FF00, "w2");
    writeReg(8'h1C, 32'h1000_0000, "w3");
    writeReg(8'h20, 32'h2000_0013, "w4");
    writeReg(8'h24, 32'h0000_2003, "w5");
    writeReg(8'h30, 32'h000A_0001, "rom");
    check("R3 all off", mapValid, 0);
    sweep();

    writeReg(8'h04, 32'h1, "cmd io");       // R3
    check("R3 io only", mapValid, 7'b0100101);
    sweep();
    writeReg(8'h04, 32'h3, "cmd both");
    check("R3 both", mapValid, 7'b1111111);
    sweep();                                 // includes R8 overlap of w1 and w3

    writeReg(8'h28, 32'h0000_5000, "stray"); // R10 ignored offset
    writeReg(8'h05, 32'h0, "misaligned");    // R10 ignored offset
    sweep();

    writeReg(8'h18, 32'h0001_0000, "io past 64K");  // R4
    check("R4 w2 dead", mapValid[2], 0);
    writeReg(8'h18, 32'h0000_FF00, "io restore");
    writeReg(8'h10, 32'h0000_0000, "io zero");       // R4
    check("R4 w0 dead", mapValid[0], 0);
    writeReg(8'h20, 32'hFFFF_FFF0, "mem top");       // R5
    check("R5 w4 dead", mapValid[4], 0);
    writeReg(8'h14, 32'h0000_0000, "mem zero");      // R5
    check("R5 w1 dead", mapValid[1], 0);
    sweep();
    writeReg(8'h20, 32'hFFFF_FFE0, "mem below top"); // R5 edge
    check("R5 w4 live", mapValid[4], 1);
    writeReg(8'h30, 32'h000A_0000, "rom off");       // R6
    check("R6 rom dead", mapValid[6], 0);
    sweep();
    writeReg(8'h30, 32'h000B_0001, "rom moved");     // R6 / R9 base move
    check("R6 rom live", mapValid[6], 1);
    writeReg(8'h04, 32'h2, "cmd mem");               // R3
    check("R3 mem only", mapValid & ISIO, 0);
    sweep();

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule